// File: doc/BRIEF.md
# Byte-Serial Auto-Increment Memory Port

This block gives a CPU byte-wide access to a 64 KiB RAM window through a 16-bit address counter that moves forward on its own. Software loads the counter with two byte writes, then streams bytes in or out with single data accesses. After each data access the counter advances by one. It does not carry across the full window. Instead it wraps inside the current 8 KiB region, so the top three counter bits stay fixed. The counter can also be read back one byte at a time. That readback has a side effect: it overwrites the counter with a copy of its own low byte.

The RAM window starts at physical 070000h, so the RAM address is that base plus the counter. The port only works while a configuration byte holds the enabling code. Reads are served from a prefetch latch, so a data read returns its byte in the cycle of the access. The latch is refilled from RAM after every access that changes the counter. Register decoding on the CPU bus is done elsewhere and reaches the block as four one-cycle strobes.

Top module: `gram_port`

## Requirements
- R1: The port is enabled only while `cfg_byte` equals 03h. While it holds any other value, all four strobes are ignored: `mem_we` stays 0, `rd_byte` is 00h, and the counter, the byte-phase toggle and the prefetch latch keep their values.
- R2: Every RAM write and every prefetch read drives `mem_addr` = 070000h + counter, so bits 20..16 are 00111b and bits 15..0 are the counter.
- R3: Each advance of the counter keeps bits 15..13 and adds one modulo 2^13 to bits 12..0. For example, 3FFFh becomes 2000h and FFFFh becomes E000h.
- R4: A data read (`rd_data_stb`) puts the byte stored at the current counter on `rd_byte` in the same cycle, then advances the counter.
- R5: A data write (`wr_data_stb`) asserts `mem_we` in its own cycle with `mem_wdata` = `wr_byte` at the current counter, then advances the counter.
- R6: Address writes (`wr_addr_stb`) load the counter's high byte when the byte-phase toggle is at "high" and the low byte when it is at "low". Each address write or address read flips the toggle, and both kinds of access share the same toggle.
- R7: An address read (`rd_addr_stb`) returns the counter's high byte when the toggle is "high" and its low byte when it is "low". After any address read, both counter bytes hold the previous low byte.
- R8: Every data read or data write sets the toggle back to "high".
- R9: After any enabled access, `mem_re` is asserted in the next cycle at the updated counter. The prefetch latch loads `mem_rdata` one cycle after that. `rd_byte` is 00h in cycles without a read strobe. Strobes must be at least three cycles apart.
- R10: Reset clears the counter to 0000h and sets the toggle to "high". A prefetch of address 0000h is issued once the port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Configuration byte; 03h enables the port |
| wr_addr_stb | input | 1 | Address write strobe |
| rd_addr_stb | input | 1 | Address read strobe |
| wr_data_stb | input | 1 | Data write strobe |
| rd_data_stb | input | 1 | Data read strobe |
| wr_byte | input | 8 | Byte written by the CPU |
| rd_byte | output | 8 | Byte returned to the CPU during a read strobe |
| mem_addr | output | 21 | Physical RAM address |
| mem_re | output | 1 | RAM read request (data returned the next cycle) |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, registered one cycle after `mem_re` |

## Verification
Results fall due at different times:

- `rd_byte` and the RAM write (`mem_we`, `mem_addr`, `mem_wdata`) are combinational in the strobe cycle. The bench samples them 1 ns after it drives the strobe, on the falling edge.
- The counter and toggle update on the rising edge that ends the strobe cycle.
- `mem_re` follows one cycle later, and the latch fills one cycle after that.

Each access is therefore followed by three idle cycles. This puts every read after the refill of the previous access has landed. The refill request itself is observed on the falling edge one cycle after a write strobe. Counter state is checked only through address reads, and the expected values come from a bench model of the RAM's initial content.

// File: rtl/gram_pkg.sv
package gram_pkg;
  // Which counter byte the next address access touches.
  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } phase_e;
endpackage

// File: rtl/gram_rst_sync.sv
module gram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/gram_addr_ctr.sv
module gram_addr_ctr
  import gram_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 2 * BYTE_W,
  parameter int REGION_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_data_i,
  input  logic              wr_data_i,
  input  logic              rd_addr_i,
  input  logic              wr_addr_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic [ADDR_W-1:0] cnt_o,
  output phase_e            phase_o
);
  localparam int KEEP_W = ADDR_W - REGION_W;

  logic [ADDR_W-1:0]   cnt_q, cnt_d;
  logic [REGION_W-1:0] low_inc;
  phase_e              ph_q, ph_d, ph_flip;
  logic                upd;

  assign low_inc = cnt_q[REGION_W-1:0] + {{(REGION_W-1){1'b0}}, 1'b1};
  assign ph_flip = (ph_q == PH_HI) ? PH_LO : PH_HI;
  assign upd     = rd_data_i | wr_data_i | rd_addr_i | wr_addr_i;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (rd_data_i || wr_data_i) begin
      cnt_d = {cnt_q[ADDR_W-1:REGION_W], low_inc};
      ph_d  = PH_HI;
    end else if (rd_addr_i) begin
      cnt_d = {cnt_q[BYTE_W-1:0], cnt_q[BYTE_W-1:0]};
      ph_d  = ph_flip;
    end else if (wr_addr_i) begin
      if (ph_q == PH_HI) cnt_d[ADDR_W-1:BYTE_W] = wr_byte_i;
      else               cnt_d[BYTE_W-1:0]      = wr_byte_i;
      ph_d = ph_flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_HI;
    end else if (upd) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = ph_q;

  AST_WRAP_KEEPS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i || wr_data_i) |=> cnt_q[ADDR_W-1:ADDR_W-KEEP_W] == $past(cnt_q[ADDR_W-1:ADDR_W-KEEP_W])); // R3
  AST_DATA_PHASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i || wr_data_i) |=> ph_q == PH_HI); // R8
  AST_ADDR_READ_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i && !rd_data_i && !wr_data_i) |=> cnt_q[ADDR_W-1:BYTE_W] == cnt_q[BYTE_W-1:0]); // R7
endmodule

// File: rtl/gram_prefetch.sv
module gram_prefetch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              refill_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] latch_o
);
  logic              pend_q, pend_d;
  logic              cap_q;
  logic              issue;
  logic [BYTE_W-1:0] latch_q;

  assign issue = pend_q & en_i;

  always_comb begin
    pend_d = pend_q;
    if (refill_i)   pend_d = 1'b1;
    else if (issue) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      cap_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cap_q  <= issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= '0;
    else if (cap_q) latch_q <= mem_rdata_i;
  end

  assign mem_re_o = issue;
  assign latch_o  = latch_q;

  AST_REFILL_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_i && en_i) |=> (mem_re_o || !en_i)); // R9
endmodule

// File: rtl/gram_port.sv
module gram_port
  import gram_pkg::*;
#(
  parameter int               BYTE_W    = 8,
  parameter int               REGION_W  = 13,
  parameter int               PHYS_W    = 21,
  parameter logic [PHYS_W-1:0] PHYS_BASE = 21'h070000,
  parameter logic [7:0]       EN_CODE   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_byte,
  input  logic              wr_addr_stb,
  input  logic              rd_addr_stb,
  input  logic              wr_data_stb,
  input  logic              rd_data_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int BASE_W = PHYS_W - ADDR_W;
  localparam logic [BASE_W-1:0] BASE_HI = PHYS_BASE[PHYS_W-1:ADDR_W];

  logic              rst_sn;
  logic              en;
  logic              g_rd_data, g_wr_data, g_rd_addr, g_wr_addr, refill;
  logic [ADDR_W-1:0] cnt;
  phase_e            phase;
  logic [BYTE_W-1:0] latch;

  gram_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign en        = (cfg_byte == EN_CODE);
  assign g_rd_data = en & rd_data_stb;
  assign g_wr_data = en & wr_data_stb;
  assign g_rd_addr = en & rd_addr_stb;
  assign g_wr_addr = en & wr_addr_stb;
  assign refill    = g_rd_data | g_wr_data | g_rd_addr | g_wr_addr;

  gram_addr_ctr #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rd_data_i (g_rd_data),
    .wr_data_i (g_wr_data),
    .rd_addr_i (g_rd_addr),
    .wr_addr_i (g_wr_addr),
    .wr_byte_i (wr_byte),
    .cnt_o     (cnt),
    .phase_o   (phase)
  );

  gram_prefetch #(.BYTE_W(BYTE_W)) u_pf (
    .clk         (clk),
    .rst_n       (rst_sn),
    .en_i        (en),
    .refill_i    (refill),
    .mem_rdata_i (mem_rdata),
    .mem_re_o    (mem_re),
    .latch_o     (latch)
  );

  assign mem_we    = g_wr_data;
  assign mem_wdata = wr_byte;
  assign mem_addr  = {BASE_HI, cnt};

  always_comb begin
    rd_byte = '0;
    if (g_rd_data)      rd_byte = latch;
    else if (g_rd_addr) rd_byte = (phase == PH_HI) ? cnt[ADDR_W-1:BYTE_W] : cnt[BYTE_W-1:0];
  end

  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    !en |-> !mem_we); // R1
  AST_OFF_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_sn)
    !en |=> $stable(cnt)); // R1
  AST_PHYS_WINDOW: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_we || mem_re) |-> mem_addr[PHYS_W-1:ADDR_W] == BASE_HI); // R2
  AST_QUIET_RD_BYTE: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rd_data_stb || rd_addr_stb) |-> rd_byte == '0); // R9
endmodule

// File: tb/test_gram_port.sv
`timescale 1ns/1ps
module test_gram_port;
  localparam int OP_WA = 0, OP_RA = 1, OP_WD = 2, OP_RD = 3;
  localparam int NV = 22;
  // entry: {op[1:0], data[7:0], expected[7:0], check}
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h3F, 8'h00, 1'b0}, {2'd0, 8'hFE, 8'h00, 1'b0},
    {2'd2, 8'h11, 8'h00, 1'b0}, {2'd2, 8'h22, 8'h00, 1'b0},  // 3FFF -> 2000 wrap, R3
    {2'd2, 8'h33, 8'h00, 1'b0}, {2'd0, 8'h3F, 8'h00, 1'b0},
    {2'd0, 8'hFE, 8'h00, 1'b0}, {2'd3, 8'h00, 8'h11, 1'b1},
    {2'd3, 8'h00, 8'h22, 1'b1}, {2'd3, 8'h00, 8'h33, 1'b1},
    {2'd1, 8'h00, 8'h20, 1'b1}, {2'd1, 8'h00, 8'h01, 1'b1},
    {2'd3, 8'h00, 8'h59, 1'b1}, {2'd1, 8'h00, 8'h01, 1'b1},
    {2'd2, 8'h44, 8'h00, 1'b0}, {2'd0, 8'h02, 8'h00, 1'b0},
    {2'd0, 8'h02, 8'h00, 1'b0}, {2'd3, 8'h00, 8'h44, 1'b1},
    {2'd0, 8'hFF, 8'h00, 1'b0}, {2'd0, 8'hFF, 8'h00, 1'b0},
    {2'd3, 8'h00, 8'h5A, 1'b1}, {2'd3, 8'h00, 8'h9B, 1'b1}   // FFFF -> E000 wrap, R3
  };

  logic        clk, rst_n;
  logic [7:0]  cfg_byte, wr_byte, rd_byte, mem_wdata, mem_rdata;
  logic        wr_addr_stb, rd_addr_stb, wr_data_stb, rd_data_stb;
  logic [20:0] mem_addr;
  logic        mem_re, mem_we;
  int          n_chk, n_fail;
  logic [7:0]  q;

  gram_port i_gram_port (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte),
    .wr_addr_stb(wr_addr_stb), .rd_addr_stb(rd_addr_stb),
    .wr_data_stb(wr_data_stb), .rd_data_stb(rd_data_stb),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // RAM model: initial content f(a) = lo ^ rotl(hi) ^ 5Ah
  logic [7:0] ram [logic [20:0]];
  function automatic logic [7:0] init_val(input logic [20:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] peek(input logic [20:0] a);
    return ram.exists(a) ? ram[a] : init_val(a);
  endfunction
  initial mem_rdata = 8'h00;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= peek(mem_addr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int op, input logic [7:0] d);
    wr_byte = d;
    wr_addr_stb = (op == OP_WA);
    rd_addr_stb = (op == OP_RA);
    wr_data_stb = (op == OP_WD);
    rd_data_stb = (op == OP_RD);
  endtask

  task automatic idle();
    wr_addr_stb = 0; rd_addr_stb = 0; wr_data_stb = 0; rd_data_stb = 0;
  endtask

  task automatic acc(input int op, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    strobe(op, d);
    #1 r = rd_byte;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 0; cfg_byte = 8'h03; wr_byte = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R10 reset state: counter 0000, phase high, prefetch of 0000
    #1 check("R9 quiet rd_byte", rd_byte, 8'h00);
    acc(OP_RA, 0, q); check("R10 counter hi", q, 8'h00);
    acc(OP_RA, 0, q); check("R10 counter lo", q, 8'h00);
    acc(OP_RD, 0, q); check("R10 prefetch at 0000", q, 8'h5A);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      acc(int'(v[18:17]), v[16:9], q);
      if (v[0]) check((v[18:17] == 2'd1) ? "R7 address read" : "R4 data read", q, v[8:1]);
    end

    // R2 / R5 write in strobe cycle, R9 refill one cycle later
    acc(OP_WA, 8'h12, q); acc(OP_WA, 8'h34, q);
    @(negedge clk);
    strobe(OP_WD, 8'h77);
    #1 check("R5 mem_we", mem_we, 1'b1);
    check("R2 write address", mem_addr, 21'h071234);
    check("R5 mem_wdata", mem_wdata, 8'h77);
    @(negedge clk);
    idle();
    #1 check("R9 refill issued", mem_re, 1'b1);
    check("R2 refill address", mem_addr, 21'h071235);
    repeat (3) @(negedge clk);

    // R6 shared toggle: address write then address read hits low byte
    acc(OP_WA, 8'h56, q);
    acc(OP_RA, 0, q); check("R6 shared toggle", q, 8'h35);

    // R8 data read resets toggle before address load
    acc(OP_RD, 0, q);
    acc(OP_WA, 8'hAB, q);
    acc(OP_RD, 0, q);
    acc(OP_WA, 8'h01, q); acc(OP_WA, 8'h03, q);
    acc(OP_RD, 0, q); check("R8 toggle reset by data read", q, 8'h5B);

    // R1 disabled port ignores everything
    acc(OP_WA, 8'h05, q); acc(OP_WA, 8'h06, q);
    acc(OP_RD, 0, q); check("R4 read 0506", q, 8'h56);
    cfg_byte = 8'h00;
    @(negedge clk);
    strobe(OP_WD, 8'h99);
    #1 check("R1 no write when off", mem_we, 1'b0);
    @(negedge clk); idle(); repeat (3) @(negedge clk);
    acc(OP_WA, 8'h12, q); acc(OP_WA, 8'h34, q);
    acc(OP_RD, 0, q); check("R1 data read off", q, 8'h00);
    acc(OP_RA, 0, q); check("R1 address read off", q, 8'h00);
    cfg_byte = 8'h03;
    repeat (4) @(negedge clk);
    acc(OP_RA, 0, q); check("R1 counter kept hi", q, 8'h05);
    acc(OP_RA, 0, q); check("R7 dup lo after read", q, 8'h07);
    acc(OP_WA, 8'h05, q); acc(OP_WA, 8'h07, q);
    acc(OP_RD, 0, q); check("R1 RAM untouched", q, 8'h57);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule